// File: doc/BRIEF.md
# BLDC Commutation Output Stage

This block turns a six-bit switch pattern into the six gate-driver pins of a brushless DC motor bridge. Software stages the next step's pattern in a shadow register at any time. The pattern becomes live on a commutation strobe from the event logic, so the step change lines up with the motor timing and not with the software write. A separate direct mode applies each pattern write at once, without waiting for a strobe.

A PWM signal is gated onto part of the live channels. Each channel belongs to a high-side or low-side group. An interval tracker follows the commutation cycle: commutation to demagnetization-end, then demagnetization-end to zero-crossing, then zero-crossing to the next commutation. A mode bit for each interval picks which group receives the PWM. A polarity mask maps logical ON to the level each driver needs.

A master enable and an active-low emergency input put the pins into a reset state fixed at build time. That state is high impedance, low or high. The emergency path forces the pins without a clock edge, clears the master enable, and can raise an interrupt.

The register write port and all strobes are plain single-cycle control inputs with no handshake. Every write is taken in the cycle it is presented, and nothing can stall the block.

Top module: `bldc_commut_out`

## Requirements
- R1: Outside direct mode, a write to address 0 only updates the shadow pattern, and the pins do not change. On the clock edge where `ev_c` is high, the shadow pattern is copied into the live pattern (bit i = channel i = pin bit i). If the shadow is written in that same cycle, the copy takes the shadow's previous value.
- R2: In direct mode (control bit 1 set), a write to address 0 loads the live pattern at that same clock edge, so the pins reflect it one cycle later.
- R3: In direct mode, `ev_d` and `ev_z` are ignored, and PWM steering always follows the zero-crossing mode bit (control bit 3).
- R4: Register 1 holds polarity. For a channel with polarity bit 1, ON drives its pin high; for polarity bit 0, ON drives it low. An OFF channel drives the opposite of its ON level.
- R5: The interval tracker starts in the zero-crossing-to-commutation interval after reset. `ev_c` always moves it to the demagnetization interval. `ev_d` is accepted only in the demagnetization interval and moves it to the back-EMF interval. `ev_z` is accepted only in the back-EMF interval and moves it back to the first interval. Any other strobe is ignored.
- R6: Register 2 assigns groups, with bit 1 meaning high-side. In each interval, a mode bit of 1 gates `pwm_in` onto the live channels of the high group, and 0 gates it onto the low group. A gated channel is OFF while `pwm_in` is low. A channel whose live pattern bit is 0 is always OFF.
- R7: The demagnetization mode bit (control bit 5) is written to a shadow copy. It takes effect only at a commutation, and from that commutation onward. The back-EMF mode bit (control bit 4) and the zero-crossing mode bit (control bit 3) act at once.
- R8: With the master enable (control bit 0) at 0, every pin is in the reset state: for high impedance, `pin_oe`=0 and `pin_out`=0; for low, `pin_oe`=1 and `pin_out`=0; for high, `pin_oe`=1 and `pin_out`=1. With the enable at 1, `pin_oe` is all ones.
- R9: While `emerg_n` is low, the pins are in the reset state with no clock edge needed. The master enable is cleared, and writes cannot set it until `emerg_n` has been high for 3 cycles. The pins therefore stay in reset after release until software re-enables them.
- R10: A falling `emerg_n` sets `irq` within 4 cycles if the mask (control bit 2) is 1, and leaves it low if the mask is 0. A control write with bit 7 set clears `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| emerg_n | input | 1 | Active-low emergency, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 pattern, 1 polarity, 2 group, 3 control |
| wr_data | input | 8 | Register write data |
| ev_c | input | 1 | Commutation strobe |
| ev_d | input | 1 | Demagnetization-end strobe |
| ev_z | input | 1 | Zero-crossing strobe |
| pwm_in | input | 1 | PWM signal |
| pin_out | output | 6 | Driver pin levels |
| pin_oe | output | 6 | Driver pin output enables |
| irq | output | 1 | Emergency interrupt request |

## Verification
The bench writes a pattern with no strobe and checks that the pins stay put. If the shadow register were missing, the step would change at the write instead of at commutation. It sends `ev_z` during demagnetization and repeats `ev_d` during back-EMF, where an order-blind tracker would send the PWM to the wrong group. It rewrites the demagnetization mode bit in the middle of that interval and checks that the old steering holds until the next commutation. It also pulls the emergency line low between clock edges and checks that the pins go to the reset state before any edge. After release, it checks that the pins stay disabled, which catches a design that merely masks the pins without clearing the enable.

// File: rtl/commut_pkg.sv
package commut_pkg;
  typedef enum logic [1:0] {IV_CD = 2'd0, IV_DZ = 2'd1, IV_ZC = 2'd2} interval_t;
  typedef enum logic [1:0] {RS_HIZ = 2'd0, RS_LOW = 2'd1, RS_HIGH = 2'd2} rst_state_t;

  localparam logic [1:0] A_PAT  = 2'd0;
  localparam logic [1:0] A_POL  = 2'd1;
  localparam logic [1:0] A_GRP  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  localparam int B_EN   = 0;
  localparam int B_DIR  = 1;
  localparam int B_MASK = 2;
  localparam int B_MZC  = 3;
  localparam int B_MDZ  = 4;
  localparam int B_MCD  = 5;
  localparam int B_ACK  = 7;
endpackage

// File: rtl/commut_regs.sv
module commut_regs
  import commut_pkg::*;
#(
  parameter int N_CH = 6,
  parameter int AW   = 2,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emerg_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            ev_c,
  output logic [N_CH-1:0] phase,
  output logic [N_CH-1:0] pol,
  output logic [N_CH-1:0] grp,
  output logic            out_en,
  output logic            direct,
  output logic            mode_zc,
  output logic            mode_dz,
  output logic            mode_cd_act,
  output logic            c_take,
  output logic            irq
);
  localparam int SYNC_N = 3;

  logic [N_CH-1:0]   pre_pat;
  logic              mask, cd_pre;
  logic [SYNC_N-1:0] em_s;
  logic              em_ok, em_fall;
  logic              wr_pat, wr_ctl;
  logic              unused_bit;

  assign unused_bit = wr_data[6];
  assign wr_pat  = wr_en && (wr_addr == A_PAT);
  assign wr_ctl  = wr_en && (wr_addr == A_CTRL);
  assign c_take  = direct ? wr_pat : ev_c;
  assign em_ok   = em_s[1];
  assign em_fall = em_s[2] && !em_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) em_s <= '1;
    else        em_s <= {em_s[SYNC_N-2:0], emerg_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_pat <= '0; phase <= '0; pol <= '0; grp <= '0;
      out_en <= 1'b0; direct <= 1'b0; mask <= 1'b0;
      mode_zc <= 1'b0; mode_dz <= 1'b0; cd_pre <= 1'b0; mode_cd_act <= 1'b0;
    end else begin
      if (wr_pat) pre_pat <= wr_data[N_CH-1:0];
      if (wr_en && wr_addr == A_POL) pol <= wr_data[N_CH-1:0];
      if (wr_en && wr_addr == A_GRP) grp <= wr_data[N_CH-1:0];
      if (wr_ctl) begin
        direct  <= wr_data[B_DIR];
        mask    <= wr_data[B_MASK];
        mode_zc <= wr_data[B_MZC];
        mode_dz <= wr_data[B_MDZ];
        cd_pre  <= wr_data[B_MCD];
      end
      if (!em_ok)      out_en <= 1'b0;
      else if (wr_ctl) out_en <= wr_data[B_EN];
      if (c_take) begin
        phase       <= direct ? wr_data[N_CH-1:0] : pre_pat;
        mode_cd_act <= cd_pre;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    irq <= 1'b0;
    else if (em_fall && mask)      irq <= 1'b1;
    else if (wr_ctl && wr_data[B_ACK]) irq <= 1'b0;
  end

  assert_preload_swap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && ev_c) |=> phase == $past(pre_pat));
  assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && wr_pat) |=> phase == $past(wr_data[N_CH-1:0]));
  assert_cd_preload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_take |=> mode_cd_act == $past(cd_pre));
  assert_emerg_clears_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !em_ok |=> !out_en);
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mask));
endmodule

// File: rtl/commut_interval.sv
module commut_interval
  import commut_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      direct,
  input  logic      c_take,
  input  logic      ev_d,
  input  logic      ev_z,
  output interval_t iv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                iv <= IV_ZC;
    else if (c_take)                           iv <= direct ? IV_ZC : IV_CD;
    else if (!direct && ev_d && iv == IV_CD)   iv <= IV_DZ;
    else if (!direct && ev_z && iv == IV_DZ)   iv <= IV_ZC;
  end

  assert_d_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && !c_take && ev_d && iv == IV_CD) |=> iv == IV_DZ);
  assert_zc_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_take && iv == IV_ZC) |=> iv == IV_ZC);
  assert_direct_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && !c_take) |=> $stable(iv));
endmodule

// File: rtl/commut_pin_drv.sv
module commut_pin_drv
  import commut_pkg::*;
#(
  parameter int         N_CH     = 6,
  parameter rst_state_t RST_MODE = RS_HIZ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] phase,
  input  logic [N_CH-1:0] pol,
  input  logic [N_CH-1:0] grp,
  input  logic            sel_high,
  input  logic            pwm_in,
  input  logic            enable,
  output logic [N_CH-1:0] pin_out,
  output logic [N_CH-1:0] pin_oe
);
  localparam logic RST_OE  = (RST_MODE != RS_HIZ);
  localparam logic RST_LVL = (RST_MODE == RS_HIGH);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic gated, on;
    assign gated      = (grp[i] == sel_high);
    assign on         = phase[i] && (!gated || pwm_in);
    assign pin_out[i] = enable ? (on ? pol[i] : !pol[i]) : RST_LVL;
    assign pin_oe[i]  = enable ? 1'b1 : RST_OE;
  end

  assert_off_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !phase[0]) |-> pin_out[0] == !pol[0]);
  assert_disabled_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (pin_oe == {N_CH{RST_OE}} && pin_out == {N_CH{RST_LVL}}));
endmodule

// File: rtl/bldc_commut_out.sv
module bldc_commut_out
  import commut_pkg::*;
#(
  parameter int         N_CH     = 6,
  parameter int         AW       = 2,
  parameter int         DW       = 8,
  parameter rst_state_t RST_MODE = RS_HIZ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emerg_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            ev_c,
  input  logic            ev_d,
  input  logic            ev_z,
  input  logic            pwm_in,
  output logic [N_CH-1:0] pin_out,
  output logic [N_CH-1:0] pin_oe,
  output logic            irq
);
  logic [N_CH-1:0] phase, pol, grp;
  logic out_en, direct, mode_zc, mode_dz, mode_cd_act, c_take, sel_high;
  interval_t iv;

  commut_regs #(.N_CH(N_CH), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .emerg_n(emerg_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ev_c(ev_c), .phase(phase), .pol(pol), .grp(grp),
    .out_en(out_en), .direct(direct), .mode_zc(mode_zc), .mode_dz(mode_dz),
    .mode_cd_act(mode_cd_act), .c_take(c_take), .irq(irq));

  commut_interval u_iv (
    .clk(clk), .rst_n(rst_n), .direct(direct), .c_take(c_take),
    .ev_d(ev_d), .ev_z(ev_z), .iv(iv));

  always_comb begin
    if (direct) sel_high = mode_zc;
    else begin
      case (iv)
        IV_CD:   sel_high = mode_cd_act;
        IV_DZ:   sel_high = mode_dz;
        default: sel_high = mode_zc;
      endcase
    end
  end

  commut_pin_drv #(.N_CH(N_CH), .RST_MODE(RST_MODE)) u_drv (
    .clk(clk), .rst_n(rst_n), .phase(phase), .pol(pol), .grp(grp),
    .sel_high(sel_high), .pwm_in(pwm_in), .enable(out_en && emerg_n),
    .pin_out(pin_out), .pin_oe(pin_oe));

  assert_emerg_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !emerg_n |-> (pin_oe == {N_CH{RST_MODE != RS_HIZ}}));
endmodule

// File: tb/sim_bldc_commut_out.sv
module sim_bldc_commut_out;
  logic clk = 1'b0, rst_n = 1'b0, emerg_n = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ev_c = 1'b0, ev_d = 1'b0, ev_z = 1'b0, pwm_in = 1'b1;
  logic [5:0] pin_out, pin_oe;
  logic irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bldc_commut_out u0 (.clk(clk), .rst_n(rst_n), .emerg_n(emerg_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ev_c(ev_c), .ev_d(ev_d), .ev_z(ev_z),
    .pwm_in(pwm_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    ev_c = (which == 0); ev_d = (which == 1); ev_z = (which == 2);
    @(negedge clk); ev_c = 1'b0; ev_d = 1'b0; ev_z = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 reset oe", pin_oe, 6'b000000);
    chk("R8 reset out", pin_out, 6'b000000);
    chk("R10 reset irq", {5'b0, irq}, 6'b0);
  endtask

  task automatic t_polarity;
    wreg(2'd1, 8'b000111);
    wreg(2'd2, 8'b000111);
    wreg(2'd3, 8'h15);
    chk("R8 enabled oe", pin_oe, 6'b111111);
    chk("R4 all off levels", pin_out, 6'b111000);
  endtask

  task automatic t_preload;
    wreg(2'd0, 8'b000011);
    chk("R1 write without C", pin_out, 6'b111000);
    pulse(0);
    chk("R1 swap on C", pin_out, 6'b111011);
  endtask

  task automatic t_steer;
    wreg(2'd0, 8'b001001);
    pulse(0);
    pwm_in = 1'b1; #1;
    chk("R6 low group pwm high", pin_out, 6'b110001);
    pwm_in = 1'b0; #1;
    chk("R6 low group pwm low", pin_out, 6'b111001);
  endtask

  task automatic t_order;
    pulse(2);
    chk("R5 Z ignored in C-D", pin_out, 6'b111001);
    pulse(1);
    chk("R5 D moves to D-Z", pin_out, 6'b110000);
    pulse(1);
    chk("R5 repeated D ignored", pin_out, 6'b110000);
    pulse(2);
    chk("R5 Z returns to Z-C", pin_out, 6'b111001);
  endtask

  task automatic t_demag;
    wreg(2'd3, 8'h35);
    pulse(0);
    chk("R7 new demag bit at C", pin_out, 6'b110000);
    wreg(2'd3, 8'h15);
    chk("R7 demag bit held mid interval", pin_out, 6'b110000);
    pulse(0);
    chk("R7 demag bit at next C", pin_out, 6'b111001);
  endtask

  task automatic t_direct;
    wreg(2'd3, 8'h17);
    wreg(2'd0, 8'b000010);
    chk("R2 direct write immediate", pin_out, 6'b111010);
    pulse(1); pulse(2);
    chk("R3 D/Z ignored in direct", pin_out, 6'b111010);
    wreg(2'd3, 8'h1F);
    chk("R3 zc bit steers high", pin_out, 6'b111000);
    pwm_in = 1'b1; #1;
    chk("R3 zc steering pwm high", pin_out, 6'b111010);
    wreg(2'd3, 8'h15);
  endtask

  task automatic t_disable;
    wreg(2'd3, 8'h14);
    chk("R8 disabled oe", pin_oe, 6'b000000);
    chk("R8 disabled out", pin_out, 6'b000000);
    wreg(2'd3, 8'h15);
    chk("R8 re-enabled oe", pin_oe, 6'b111111);
  endtask

  task automatic t_emerg;
    @(negedge clk); #3; emerg_n = 1'b0; #1;
    chk("R9 async force oe", pin_oe, 6'b000000);
    repeat (5) @(negedge clk);
    chk("R10 irq raised", {5'b0, irq}, 6'b000001);
    emerg_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 stays off after release", pin_oe, 6'b000000);
    wreg(2'd3, 8'h95);
    chk("R10 irq cleared", {5'b0, irq}, 6'b0);
    chk("R9 re-enabled", pin_oe, 6'b111111);
    wreg(2'd3, 8'h11);
    emerg_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 masked no irq", {5'b0, irq}, 6'b0);
    emerg_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_polarity();
    t_preload();
    t_steer();
    t_order();
    t_demag();
    t_direct();
    t_disable();
    t_emerg();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule